// File: doc/BRIEF.md
# Supply Fault Qualifier with Undervoltage Debounce

This block sits between the analog monitors of a smart-card power stage and the power sequencer that runs the card's activation and deactivation steps. It receives raw comparator flags for five conditions: logic supply below a low threshold, logic supply below a higher threshold, card supply over-current, over-temperature and card removal. It also receives a threshold-select strap. From these it produces a single qualified power-down request for the sequencer and an active-low fault indication for the host.

Every asynchronous flag and the strap first pass through a synchronizer chain. The strap decides which undervoltage comparator counts and how it is treated. With the strap high, the low-threshold comparator is used and acts at once. With the strap low, the higher-threshold comparator is used, and a crossing must last a parameterised number of clock cycles before it counts, so that short supply dips do not power the card down. Over-current, over-temperature and card removal are never filtered.

The outputs do not latch. The request falls again once every qualified source has cleared. Holding the power-down state is the sequencer's job.

Top module: `supply_fault_qual`

## Requirements
- R1: While rst_ni is low, and after its release until a source is seen, fault_req_o is 0 and fault_n_o is 1.
- R2: A high ovc_i sampled at a rising clock edge drives fault_req_o to 1 and fault_n_o to 0 after exactly 3 rising edges (2 synchronizer flops plus 1 output flop), and not after 2.
- R3: A high otemp_i drives fault_req_o to 1 with the same 3-edge latency and leaves fault_n_o at 1.
- R4: card_gone_i raises fault_req_o only while card_active_i is 1; with card_active_i at 0 it has no effect on either output.
- R5: With thr_sel_i = 1 (low threshold selected), a high uv_low_i drives fault_req_o to 1 and fault_n_o to 0 after 3 edges, without filtering.
- R6: With thr_sel_i = 1, uv_high_i has no effect on either output, however long it is held.
- R7: With thr_sel_i = 0 (higher threshold selected), uv_high_i held high for DEB_CYC consecutive sampling edges or more raises fault_req_o, with fault_n_o left at 1.
- R8: With thr_sel_i = 0, a uv_high_i pulse of fewer than DEB_CYC sampling edges never raises fault_req_o. One sampled low edge clears the count, so two short pulses never add up.
- R9: With thr_sel_i = 0, uv_low_i has no effect on either output.
- R10: fault_req_o is 0 whenever no source was qualifying 3 edges earlier, and it returns to 0 once all sources clear; nothing latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_sel_i | input | 1 | Strap: 1 = low threshold, immediate; 0 = higher threshold, debounced |
| uv_low_i | input | 1 | Async flag: logic supply below the low threshold |
| uv_high_i | input | 1 | Async flag: logic supply below the higher threshold |
| ovc_i | input | 1 | Async flag: card supply over-current |
| otemp_i | input | 1 | Async flag: over-temperature |
| card_gone_i | input | 1 | Async flag: card not present |
| card_active_i | input | 1 | Synchronous: card is currently powered |
| fault_req_o | output | 1 | Qualified power-down request to the sequencer |
| fault_n_o | output | 1 | Active-low fault indication (over-current or low-threshold undervoltage) |

## Verification
The hardest case to reach from the ports is the exact debounce boundary. A dip must stay high for precisely DEB_CYC−1 or DEB_CYC sampling edges, as seen after the synchronizer. The stimulus drives uv_high_i only between edges, holds it for a counted number of rising edges, and sweeps that count from 1 to DEB_CYC+2 on a small debounce setting. It watches the request over the whole window. Two back-to-back sub-threshold dips separated by a single low edge check that the count cannot carry over from one dip to the next.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  typedef struct packed {
    logic thr_sel;
    logic uv_low;
    logic uv_high;
    logic ovc;
    logic otemp;
    logic card_gone;
  } mon_t;

  localparam int unsigned MON_W = $bits(mon_t);
endpackage

// File: rtl/sfq_sync.sv
module sfq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sfq_debounce.sv
module sfq_debounce #(
  parameter int unsigned DEB_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEB_CYC - 1);
  localparam logic [CW-1:0] SAT   = CW'(DEB_CYC);

  logic [CW-1:0] cnt_q;

  // count of consecutive earlier hits; any miss restarts from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!hit_i)       cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = hit_i && (cnt_q >= LIMIT);
endmodule

// File: rtl/supply_fault_qual.sv
module supply_fault_qual
  import sfq_pkg::*;
#(
  parameter int unsigned DEB_CYC     = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_sel_i,
  input  logic uv_low_i,
  input  logic uv_high_i,
  input  logic ovc_i,
  input  logic otemp_i,
  input  logic card_gone_i,
  input  logic card_active_i,
  output logic fault_req_o,
  output logic fault_n_o
);
  mon_t raw, syn;
  logic [MON_W-1:0] syn_bits;
  logic uvh_hit, uvh_qual, uvl_fault, req_d, ind_d;
  logic req_q, ind_q;

  assign raw = '{thr_sel: thr_sel_i, uv_low: uv_low_i, uv_high: uv_high_i,
                 ovc: ovc_i, otemp: otemp_i, card_gone: card_gone_i};

  sfq_sync #(.WIDTH(MON_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn_bits)
  );
  assign syn = mon_t'(syn_bits);

  assign uvh_hit = syn.uv_high && !syn.thr_sel;

  sfq_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (uvh_hit),
    .qual_o (uvh_qual)
  );

  assign uvl_fault = syn.uv_low && syn.thr_sel;
  assign ind_d     = syn.ovc || uvl_fault;
  assign req_d     = ind_d || syn.otemp || (syn.card_gone && card_active_i) || uvh_qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ind_q <= 1'b0;
    end else begin
      req_q <= req_d;
      ind_q <= ind_d;
    end
  end

  assign fault_req_o = req_q;
  assign fault_n_o   = !ind_q;
endmodule

// File: rtl/supply_fault_qual_chk.sv
module supply_fault_qual_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic thr_sel_i,
  input logic uv_low_i,
  input logic uv_high_i,
  input logic ovc_i,
  input logic otemp_i,
  input logic card_gone_i,
  input logic card_active_i,
  input logic fault_req_o,
  input logic fault_n_o
);
  localparam int unsigned LAT = SYNC_STAGES + 1;

  logic [3:0] since_rst;
  logic ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst <= '0;
    else if (since_rst != 4'hf) since_rst <= since_rst + 1'b1;
  end
  assign ok = since_rst >= 4'(LAT);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!fault_req_o && fault_n_o));

  assert_ovc_fault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && $past(ovc_i, LAT) |-> (fault_req_o && !fault_n_o));

  assert_low_thr_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && $past(uv_low_i, LAT) && $past(thr_sel_i, LAT) |-> (fault_req_o && !fault_n_o));

  assert_indication_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !$past(ovc_i, LAT) && !($past(uv_low_i, LAT) && $past(thr_sel_i, LAT))
      |-> fault_n_o);

  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !$past(ovc_i, LAT) && !$past(otemp_i, LAT) && !$past(uv_high_i, LAT)
       && !($past(card_gone_i, LAT) && $past(card_active_i, 1))
       && !($past(uv_low_i, LAT) && $past(thr_sel_i, LAT))
      |-> !fault_req_o);
endmodule

bind supply_fault_qual supply_fault_qual_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .thr_sel_i     (thr_sel_i),
  .uv_low_i      (uv_low_i),
  .uv_high_i     (uv_high_i),
  .ovc_i         (ovc_i),
  .otemp_i       (otemp_i),
  .card_gone_i   (card_gone_i),
  .card_active_i (card_active_i),
  .fault_req_o   (fault_req_o),
  .fault_n_o     (fault_n_o)
);

// File: tb/supply_fault_qual_test.sv
module supply_fault_qual_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 6;
  localparam int WATCHDOG_CYC = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_sel = 1'b1, uv_low = 1'b0, uv_high = 1'b0, ovc = 1'b0;
  logic otemp = 1'b0, card_gone = 1'b0, card_active = 1'b0;
  logic fault_req, fault_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_fault_qual #(.DEB_CYC(DEB), .SYNC_STAGES(2)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .thr_sel_i     (thr_sel),
    .uv_low_i      (uv_low),
    .uv_high_i     (uv_high),
    .ovc_i         (ovc),
    .otemp_i       (otemp),
    .card_gone_i   (card_gone),
    .card_active_i (card_active),
    .fault_req_o   (fault_req),
    .fault_n_o     (fault_n)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    uv_low = 0; uv_high = 0; ovc = 0; otemp = 0; card_gone = 0; card_active = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise uv_high for n sampling edges, report whether a request was seen
  task automatic dip(input int n, output bit seen);
    seen = 0;
    @(negedge clk);
    uv_high = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fault_req) seen = 1;
    end
    uv_high = 0;
    for (int i = 0; i < DEB + 4; i++) begin
      @(negedge clk);
      if (fault_req) seen = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    // R1 reset state
    settle(3);
    check(!fault_req && fault_n, "R1", "in reset req/ind_n", {fault_req, fault_n}, 1);
    ovc = 1;
    settle(2);
    check(!fault_req && fault_n, "R1", "reset masks ovc", {fault_req, fault_n}, 1);
    ovc = 0;
    settle(1);
    rst_n = 1;
    settle(4);
    check(!fault_req && fault_n, "R1", "after release", {fault_req, fault_n}, 1);

    // R2 latency: 3 edges, not 2
    ovc = 1;
    settle(2);
    check(!fault_req, "R2", "req after 2 edges", fault_req, 0);
    settle(1);
    check(fault_req && !fault_n, "R2", "req/ind_n after 3 edges", {fault_req, fault_n}, 2);
    ovc = 0;
    settle(3);
    check(!fault_req && fault_n, "R10", "release after ovc", {fault_req, fault_n}, 1);

    // R3 over-temperature latency
    otemp = 1;
    settle(2);
    check(!fault_req, "R3", "otemp after 2 edges", fault_req, 0);
    settle(1);
    check(fault_req && fault_n, "R3", "otemp after 3 edges", {fault_req, fault_n}, 3);
    otemp = 0;
    settle(4);

    // near-exhaustive sweep of immediate sources: R2 R3 R4 R5 R9 R10
    for (int v = 0; v < 64; v++) begin
      bit exp_req, exp_ind;
      ovc         = v[0];
      otemp       = v[1];
      card_gone   = v[2];
      card_active = v[3];
      uv_low      = v[4];
      thr_sel     = v[5];
      settle(4);
      exp_ind = v[0] || (v[4] && v[5]);
      exp_req = exp_ind || v[1] || (v[2] && v[3]);
      check(fault_req == exp_req, "R4/R5/R9 sweep (R10)", $sformatf("req vec=%0d", v),
            fault_req, exp_req);
      check(fault_n == !exp_ind, "R2/R3/R5/R9 sweep", $sformatf("ind_n vec=%0d", v),
            fault_n, !exp_ind);
    end
    clear_all();
    settle(4);
    check(!fault_req, "R10", "all clear after sweep", fault_req, 0);

    // R4 explicit: removal ignored while inactive
    card_gone = 1; card_active = 0;
    settle(DEB + 4);
    check(!fault_req && fault_n, "R4", "removal while inactive", {fault_req, fault_n}, 1);
    card_active = 1;
    settle(1);
    check(fault_req, "R4", "removal while active", fault_req, 1);
    clear_all();
    settle(4);

    // R6 higher comparator ignored under low-threshold select
    thr_sel = 1;
    settle(4);
    dip(DEB * 3, seen);
    check(!seen, "R6", "uv_high with low threshold", seen, 0);

    // R7 / R8 boundary sweep under higher-threshold select
    thr_sel = 0;
    settle(4);
    for (int n = 1; n <= DEB + 2; n++) begin
      bit exp_seen;
      exp_seen = (n >= DEB);
      dip(n, seen);
      check(seen == exp_seen, n >= DEB ? "R7" : "R8", $sformatf("dip len=%0d", n),
            seen, exp_seen);
    end

    // R7 latency and indication: request after DEB+2 edges, fault_n stays high
    @(negedge clk);
    uv_high = 1;
    settle(DEB + 1);
    check(!fault_req, "R7", "one edge before qualify", fault_req, 0);
    settle(1);
    check(fault_req && fault_n, "R7", "qualified req/ind_n", {fault_req, fault_n}, 3);
    uv_high = 0;
    settle(3);
    check(!fault_req, "R10", "release after dip", fault_req, 0);

    // R8 two sub-limit dips split by one low edge do not accumulate
    seen = 0;
    @(negedge clk);
    uv_high = 1;
    for (int i = 0; i < DEB - 1; i++) begin @(negedge clk); if (fault_req) seen = 1; end
    uv_high = 0;
    @(negedge clk);
    if (fault_req) seen = 1;
    uv_high = 1;
    for (int i = 0; i < DEB - 1; i++) begin @(negedge clk); if (fault_req) seen = 1; end
    uv_high = 0;
    for (int i = 0; i < DEB + 4; i++) begin @(negedge clk); if (fault_req) seen = 1; end
    check(!seen, "R8", "split dips", seen, 0);

    // R9 low comparator ignored under higher-threshold select
    uv_low = 1;
    settle(DEB + 4);
    check(!fault_req && fault_n, "R9", "uv_low with high threshold", {fault_req, fault_n}, 1);
    uv_low = 0;
    settle(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule